// File: doc/BRIEF.md
# Wiper Position Controller

This block is the digital control section of a 32-tap digitally controlled potentiometer. A host drives three asynchronous pins: an active-low select, an increment strobe and an up/down level. The block samples them on the system clock and keeps a wiper position that saturates at either end and never wraps. It drives the position both as a binary code and as a one-hot tap select for the analog switch network.

When the select is released, the level of the increment pin at that moment decides whether the position is written into a modelled nonvolatile register. A write holds the block busy for a parameterised number of cycles. The register keeps its content across reset, and the block reloads the position from it on the first cycle after reset. This is the power-up recall.

Top module: `wiper_ctrl`

## Requirements
- R1: While select is high (deselected), increment and up/down activity leaves the position unchanged.
- R2: Each high-to-low transition of the increment pin while selected moves the position by one. Up/down high (1) steps up and low (0) steps down.
- R3: The position saturates at 0 and at TAPS-1 (31). A step past either end leaves it unchanged.
- R4: Releasing select while increment is high writes the current position into the nonvolatile register and raises busy_o for exactly STORE_CYCLES cycles. The block then returns to standby.
- R5: Releasing select while increment is low stores nothing and never raises busy_o. The position is kept.
- R6: On the first cycle after reset the position is loaded from the nonvolatile register. Before any store this register holds NV_INIT. Its content survives rst_ni.
- R7: While busy_o is high, increment edges and select edges are ignored. A select release during busy starts no second store.
- R8: The up/down level may change while select stays low. Later steps follow the new level.
- R9: A falling increment edge counts only if the increment pin was high for at least INC_HIGH_MIN synchronised cycles before it. Shorter high pulses are ignored.
- R10: tap_o has exactly one bit set, and that bit's index equals pos_o.
- R11: standby_o is high exactly when the block is deselected and not busy.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset (power-up) |
| cs_ni | input | 1 | Asynchronous select, low = selected |
| inc_i | input | 1 | Asynchronous increment strobe, falling edge steps |
| up_i | input | 1 | Asynchronous direction level, 1 = up, 0 = down |
| pos_o | output | POS_W (5) | Binary wiper position |
| tap_o | output | TAPS (32) | One-hot tap select |
| busy_o | output | 1 | Nonvolatile write in progress |
| standby_o | output | 1 | Deselected and idle |

## Verification
Stepping is tried with runs of up strobes, a direction change inside one selection, and long runs driven into both ends. Together these separate plain counting from saturation and from wrap-around. Select is released once with increment low and once with increment high, each followed by a reset. The recalled value then shows whether a write happened, and the busy length is counted cycle by cycle. A one-cycle increment glitch, strobes while deselected, and strobes and select edges during busy separate the qualified edges from the ignored ones.

// File: rtl/wiper_pkg.sv
package wiper_pkg;
  typedef struct packed {
    logic sel_n;
    logic inc;
    logic up;
  } ctl_t;

  localparam ctl_t CTL_IDLE = '{sel_n: 1'b1, inc: 1'b1, up: 1'b0};
endpackage

// File: rtl/wiper_sync.sv
module wiper_sync #(
  parameter int             W       = 3,
  parameter int             STAGES  = 2,
  parameter logic [W-1:0]   RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [STAGES-1:0][W-1:0] stg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s < STAGES; s++) stg_q[s] <= RST_VAL;
    end else begin
      stg_q[0] <= d_i;
      for (int s = 1; s < STAGES; s++) stg_q[s] <= stg_q[s-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/wiper_pos_cnt.sv
module wiper_pos_cnt #(
  parameter int TAPS  = 32,
  parameter int POS_W = $clog2(TAPS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [POS_W-1:0] load_val_i,
  input  logic             step_i,
  input  logic             up_i,
  output logic [POS_W-1:0] pos_o
);
  localparam logic [POS_W-1:0] POS_MAX = POS_W'(TAPS - 1);

  logic [POS_W-1:0] pos_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pos_q <= '0;
    end else if (load_i) begin
      pos_q <= load_val_i;
    end else if (step_i) begin
      if (up_i && pos_q != POS_MAX)      pos_q <= pos_q + 1'b1;
      else if (!up_i && pos_q != '0)     pos_q <= pos_q - 1'b1;
    end
  end

  assign pos_o = pos_q;

  AST_HOLD_NO_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && !step_i) |=> $stable(pos_q)); // R1
  AST_UP_BY_ONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && up_i && !load_i && pos_q != POS_MAX) |=> (pos_q == POS_W'($past(pos_q) + 1'b1))); // R2
  AST_TOP_NO_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pos_q == POS_MAX && !load_i) |=> (pos_q != '0)); // R3
  AST_BOT_NO_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pos_q == '0 && !load_i) |=> (pos_q != POS_MAX)); // R3
endmodule

// File: rtl/wiper_tap_dec.sv
module wiper_tap_dec #(
  parameter int TAPS  = 32,
  parameter int POS_W = $clog2(TAPS)
) (
  input  logic [POS_W-1:0] pos_i,
  output logic [TAPS-1:0]  tap_o
);
  for (genvar t = 0; t < TAPS; t++) begin : g_tap
    assign tap_o[t] = (pos_i == POS_W'(t));
  end
endmodule

// File: rtl/wiper_nv_store.sv
module wiper_nv_store #(
  parameter int POS_W        = 5,
  parameter int STORE_CYCLES = 2_000_000,
  parameter int NV_INIT      = 0,
  parameter int CNT_W        = $clog2(STORE_CYCLES + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [POS_W-1:0] pos_i,
  output logic             busy_o,
  output logic [POS_W-1:0] nv_o
);
  // nonvolatile model: content set at power-on only, never cleared by rst_ni
  logic [POS_W-1:0] nv_q = POS_W'(NV_INIT);
  logic             busy_q;
  logic [CNT_W-1:0] cnt_q;
  logic             accept;

  assign accept = start_i && !busy_q;

  always_ff @(posedge clk_i) begin
    if (accept) nv_q <= pos_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else if (accept) begin
      busy_q <= 1'b1;
      cnt_q  <= CNT_W'(STORE_CYCLES - 1);
    end else if (busy_q) begin
      if (cnt_q == '0) busy_q <= 1'b0;
      else             cnt_q  <= cnt_q - 1'b1;
    end
  end

  assign busy_o = busy_q;
  assign nv_o   = nv_q;

  AST_NV_CAPTURE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_q) |-> (nv_q == $past(pos_i))); // R4
  AST_NV_KEEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !accept |=> $stable(nv_q)); // R5
endmodule

// File: rtl/wiper_ctrl.sv
module wiper_ctrl
  import wiper_pkg::*;
#(
  parameter int TAPS         = 32,
  parameter int STORE_CYCLES = 2_000_000,
  parameter int INC_HIGH_MIN = 3,
  parameter int NV_INIT      = 0,
  parameter int POS_W        = $clog2(TAPS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cs_ni,
  input  logic             inc_i,
  input  logic             up_i,
  output logic [POS_W-1:0] pos_o,
  output logic [TAPS-1:0]  tap_o,
  output logic             busy_o,
  output logic             standby_o
);
  localparam int HI_W = $clog2(INC_HIGH_MIN + 1);

  logic [2:0]       sync_q;
  ctl_t             cur;
  logic             sel_prev_q, inc_prev_q;
  logic [HI_W-1:0]  hi_cnt_q;
  logic             recall_q;
  logic             inc_fall, sel_rise, hi_ok, step, store_start;
  logic [POS_W-1:0] nv_val;

  wiper_sync #(.W(3), .STAGES(2), .RST_VAL(CTL_IDLE)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({cs_ni, inc_i, up_i}),
    .q_o   (sync_q)
  );

  assign cur = ctl_t'(sync_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sel_prev_q <= 1'b1;
      inc_prev_q <= 1'b1;
      hi_cnt_q   <= '0;
      recall_q   <= 1'b1;
    end else begin
      sel_prev_q <= cur.sel_n;
      inc_prev_q <= cur.inc;
      recall_q   <= 1'b0;
      if (!cur.inc)                             hi_cnt_q <= '0;
      else if (hi_cnt_q != HI_W'(INC_HIGH_MIN)) hi_cnt_q <= hi_cnt_q + 1'b1;
    end
  end

  assign inc_fall    = inc_prev_q && !cur.inc;
  assign sel_rise    = !sel_prev_q && cur.sel_n;
  assign hi_ok       = hi_cnt_q >= HI_W'(INC_HIGH_MIN);
  assign step        = inc_fall && hi_ok && !cur.sel_n && !busy_o && !recall_q;
  assign store_start = sel_rise && cur.inc && !busy_o && !recall_q;

  wiper_nv_store #(.POS_W(POS_W), .STORE_CYCLES(STORE_CYCLES), .NV_INIT(NV_INIT)) u_nv (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .start_i(store_start),
    .pos_i  (pos_o),
    .busy_o (busy_o),
    .nv_o   (nv_val)
  );

  wiper_pos_cnt #(.TAPS(TAPS), .POS_W(POS_W)) u_cnt (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_i    (recall_q),
    .load_val_i(nv_val),
    .step_i    (step),
    .up_i      (cur.up),
    .pos_o     (pos_o)
  );

  wiper_tap_dec #(.TAPS(TAPS), .POS_W(POS_W)) u_dec (
    .pos_i(pos_o),
    .tap_o(tap_o)
  );

  assign standby_o = cur.sel_n && !busy_o;

  AST_DESEL_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cur.sel_n && !recall_q) |=> $stable(pos_o)); // R1
  AST_NO_STORE_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_rise && !cur.inc) |=> !$rose(busy_o)); // R5
  AST_BUSY_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |=> $stable(pos_o)); // R7
  AST_SHORT_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inc_fall && !hi_ok && !recall_q) |=> $stable(pos_o)); // R9
  AST_TAP_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(tap_o) == 1); // R10
  AST_TAP_MATCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tap_o[pos_o]); // R10
  AST_STBY_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    standby_o |-> !busy_o); // R11
endmodule

// File: tb/test_wiper_ctrl.sv
`timescale 1ns/1ps
module test_wiper_ctrl;
  localparam int TAPS  = 32;
  localparam int STORE = 40;
  localparam int HMIN  = 3;
  localparam int NVI   = 16;

  typedef struct {
    logic [4:0] pos;
    logic       busy;
    logic       stby;
    string      req;
  } exp_t;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic cs_ni = 1'b1, inc_i = 1'b1, up_i = 1'b0;
  logic [4:0]  pos_o;
  logic [31:0] tap_o;
  logic busy_o, standby_o;
  int checks = 0, errors = 0;
  exp_t q[$];

  always #2.5 clk = ~clk;

  wiper_ctrl #(.TAPS(TAPS), .STORE_CYCLES(STORE), .INC_HIGH_MIN(HMIN), .NV_INIT(NVI)) i_wiper_ctrl (
    .clk_i(clk), .rst_ni(rst_ni), .cs_ni(cs_ni), .inc_i(inc_i), .up_i(up_i),
    .pos_o(pos_o), .tap_o(tap_o), .busy_o(busy_o), .standby_o(standby_o)
  );

  // monitor: compares expected items as they arrive
  always @(negedge clk) begin : mon
    exp_t e;
    if (q.size() != 0) begin
      e = q.pop_front();
      checks++;
      if (pos_o !== e.pos || tap_o !== (32'd1 << e.pos) || busy_o !== e.busy || standby_o !== e.stby) begin
        errors++;
        $display("FAIL %s: pos=%0d tap=%h busy=%b stby=%b expected pos=%0d tap=%h busy=%b stby=%b",
                 e.req, pos_o, tap_o, busy_o, standby_o, e.pos, 32'd1 << e.pos, e.busy, e.stby);
      end
    end
  end

  task automatic wait_n(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic expect_state(int pos, bit busy, bit stby, string req);
    exp_t e;
    wait_n(6);
    @(posedge clk); #1;
    e.pos = 5'(pos); e.busy = busy; e.stby = stby; e.req = req;
    q.push_back(e);
    @(negedge clk); #1;
  endtask

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic pulse(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); inc_i = 1'b0;
      wait_n(8);
      inc_i = 1'b1;
      wait_n(8);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst_ni = 1'b0; cs_ni = 1'b1; inc_i = 1'b1;
    wait_n(4);
    rst_ni = 1'b1;
  endtask

  task automatic wait_busy_rise(string req);
    int n = 0;
    while (!busy_o && n < 12) begin @(negedge clk); n++; end
    chk(busy_o === 1'b1, req, int'(busy_o), 1);
  endtask

  task automatic report();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin : watchdog
    #500000;
    errors++;
    $display("FAIL watchdog: actual=hung expected=done");
    report();
  end

  initial begin : driver
    int len;
    wait_n(3);
    rst_ni = 1'b1;
    expect_state(NVI, 0, 1, "R6 R10 R11 recall of initial content");
    @(negedge clk); cs_ni = 1'b0;
    expect_state(NVI, 0, 0, "R11 selected is not standby");
    up_i = 1'b1; pulse(3);
    expect_state(19, 0, 0, "R2 three up steps");
    up_i = 1'b0; pulse(1);
    expect_state(18, 0, 0, "R8 direction change within selection");
    up_i = 1'b1; pulse(20);
    expect_state(31, 0, 0, "R3 saturate at top");
    up_i = 1'b0; pulse(40);
    expect_state(0, 0, 0, "R3 saturate at bottom");
    up_i = 1'b1; pulse(5);
    expect_state(5, 0, 0, "R2 up from bottom");
    // qualified fall, then a one-cycle high glitch
    @(negedge clk); inc_i = 1'b0;
    wait_n(8);
    inc_i = 1'b1; wait_n(1); inc_i = 1'b0;
    expect_state(6, 0, 0, "R9 short high pulse ignored");
    // release with increment low: no store
    @(negedge clk); cs_ni = 1'b1;
    wait_n(2);
    chk(busy_o === 1'b0, "R5 no busy after release with inc low", int'(busy_o), 0);
    expect_state(6, 0, 1, "R5 position kept");
    wait_n(4); inc_i = 1'b1; wait_n(8);
    pulse(2); up_i = 1'b0; pulse(2);
    expect_state(6, 0, 1, "R1 deselected strobes ignored");
    do_reset();
    expect_state(NVI, 0, 1, "R5 R6 nothing stored, old content recalled");
    // store path
    @(negedge clk); cs_ni = 1'b0;
    wait_n(4); up_i = 1'b1; pulse(2);
    expect_state(18, 0, 0, "R2 steps before store");
    @(negedge clk); cs_ni = 1'b1;
    wait_busy_rise("R4 busy rises on release with inc high");
    chk(standby_o === 1'b0, "R11 no standby during busy", int'(standby_o), 0);
    len = 0;
    while (busy_o && len < 1000) begin @(negedge clk); len++; end
    chk(len == STORE, "R4 busy length", len, STORE);
    expect_state(18, 0, 1, "R4 standby after store");
    do_reset();
    expect_state(18, 0, 1, "R6 stored value recalled");
    // activity during busy
    @(negedge clk); cs_ni = 1'b0;
    wait_n(4); pulse(1);
    expect_state(19, 0, 0, "R2 step before second store");
    @(negedge clk); cs_ni = 1'b1;
    wait_busy_rise("R4 second store starts");
    wait_n(2); cs_ni = 1'b0;
    wait_n(4); inc_i = 1'b0;
    wait_n(6); inc_i = 1'b1;
    wait_n(4); cs_ni = 1'b1;
    len = 0;
    while (busy_o && len < 1000) begin @(negedge clk); len++; end
    wait_n(4);
    chk(busy_o === 1'b0, "R7 release during busy starts no store", int'(busy_o), 0);
    expect_state(19, 0, 1, "R7 strobe during busy ignored");
    do_reset();
    expect_state(19, 0, 1, "R4 R6 second stored value recalled");
    report();
  end
endmodule